// File: doc/BRIEF.md
# Packed SIMD Rounding Shift-Accumulate Unit

This unit takes a packed source vector and a packed accumulator vector. In every element it shifts the source right by an immediate amount and rounds the result to nearest. It then adds that value to the matching accumulator element. Elements are 8, 16, 32 or 64 bits wide, and the vector is either 64 or 128 bits. Each element is computed on its own, and no carry ever reaches a neighbouring element. Signed elements use an arithmetic shift. Unsigned elements shift in zeros.

Rounding adds half of the weight of the lowest kept bit before the shift. That sum is formed in a width wider than the element, so an all-ones or maximum-positive input cannot lose its carry. A shift equal to the full element width is legal. A shift of zero or one greater than the element width is flagged as an error, and in that case the accumulator passes through unchanged. One register stage sits between the inputs and the outputs, and a valid flag travels alongside the data.

Top module: `rsa_vec_unit`

## Requirements
- R1: `esize` selects the element width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) and `wide_sel` selects the vector size (0 = 64 bits in `src[63:0]`/`acc[63:0]`, 1 = 128 bits). Each element is computed independently, so a wrap in one lane never changes another lane.
- R2: The rounding term 2^(n-1) is added to the source element before the right shift by n. The add does not lose a carry: an unsigned 8-bit 0xFF shifted by 1 gives 0x80, a signed 0x7F gives 0x40 for n=1 and 0x10 for n=3, and an unsigned 0xFF shifted by 3 gives 0x20.
- R3: Signed elements shift arithmetically. The minimum value 0x80 gives 0xC0 for n=1, 0xF0 for n=3 and 0x00 for n=8, and the same pattern holds at every element width.
- R4: A shift equal to the element width is legal: all-ones unsigned input gives 1, and maximum signed input gives 0.
- R5: The rounded value is added to the accumulator element modulo 2^w, with no saturation. For example, 0xFFFF + 1 in a 16-bit lane gives 0x0000.
- R6: A shift of 0 or greater than the element width sets `shamt_err`, and `result` then equals the accumulator (its upper half still zero in 64-bit mode).
- R7: In 64-bit mode `result[127:64]` is zero, and the upper halves of `src` and `acc` have no effect.
- R8: `result`, `shamt_err` and `out_valid` update exactly one clock after `in_valid` is high. `out_valid` is low one clock after `in_valid` is low, and `result` holds its value while no new input is accepted.
- R9: Asserting `rst_n` low clears `out_valid`, `shamt_err` and `result` to zero at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| wide_sel | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| esize | input | 2 | Element width code (8 << esize bits) |
| is_signed | input | 1 | 1 = signed elements, arithmetic shift |
| shamt | input | 7 | Right-shift immediate, legal range 1 to element width |
| src | input | 128 | Packed source vector |
| acc | input | 128 | Packed accumulator vector |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 128 | Packed accumulated result |
| shamt_err | output | 1 | Last accepted shift amount was out of range |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector and a 7-bit shift field. This gives it all four element widths in both vector sizes. The 7-bit field can hold values both just past each element width and the full width of 64-bit lanes, so the legal and illegal shift boundaries can be driven at every size. Directed items cover the carry-preserving rounding cases, the signed-minimum cases and the lane wrap cases. Randomly drawn operands are then scored against a reference built from the requirements.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  // Element width selector; the code value is the log2 of (width / 8).
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_t;

  localparam int unsigned NUM_ESZ  = 4;
  localparam int unsigned MIN_EW   = 8;

  function automatic int unsigned esz_bits(input int unsigned code);
    return MIN_EW << code;
  endfunction
endpackage

// File: rtl/rsa_lane.sv
// One element: acc + round(src >> n), all in a working width two bits wider
// than the element so the rounding carry and the sign survive.
module rsa_lane #(
  parameter int unsigned EW  = 8,
  parameter int unsigned SHW = 7
) (
  input  logic [EW-1:0]  src_i,
  input  logic [EW-1:0]  acc_i,
  input  logic           is_signed_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [EW-1:0]  sum_o
);
  localparam int unsigned XW = EW + 2;

  logic [XW-1:0] ext;
  logic [XW-1:0] rnd;
  logic [XW-1:0] biased;
  logic [XW-1:0] shifted;

  always_comb begin
    ext     = {{2{is_signed_i & src_i[EW-1]}}, src_i};
    // shamt of zero wraps to a huge shift and yields zero; the top masks it.
    rnd     = XW'(1) << (shamt_i - SHW'(1));
    biased  = ext + rnd;
    shifted = $signed(biased) >>> shamt_i;
    sum_o   = EW'(acc_i + shifted);
  end
endmodule

// File: rtl/rsa_lane_array.sv
// All lanes of one element width across the full vector.
module rsa_lane_array #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 8,
  parameter int unsigned SHW   = 7
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] acc_i,
  input  logic             is_signed_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned LANES = VEC_W / EW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rsa_lane #(.EW(EW), .SHW(SHW)) u_lane (
      .src_i       (src_i[g*EW +: EW]),
      .acc_i       (acc_i[g*EW +: EW]),
      .is_signed_i (is_signed_i),
      .shamt_i     (shamt_i),
      .sum_o       (res_o[g*EW +: EW])
    );
  end
endmodule

// File: rtl/rsa_shamt_check.sv
// Flags a shift immediate outside 1 .. element width.
module rsa_shamt_check #(
  parameter int unsigned SHW = 7
) (
  input  logic [1:0]     esize_i,
  input  logic [SHW-1:0] shamt_i,
  output logic           illegal_o
);
  logic [SHW-1:0] limit;

  always_comb begin
    limit     = SHW'(rsa_pkg::MIN_EW) << esize_i;
    illegal_o = (shamt_i == '0) || (shamt_i > limit);
  end
endmodule

// File: rtl/rsa_vec_unit.sv
module rsa_vec_unit #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned SHW   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             wide_sel,
  input  logic [1:0]       esize,
  input  logic             is_signed,
  input  logic [SHW-1:0]   shamt,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] acc,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             shamt_err
);
  import rsa_pkg::*;

  localparam int unsigned HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] lane_res [NUM_ESZ];
  logic [VEC_W-1:0] res_d;
  logic             illegal;
  logic             valid_q;
  logic [VEC_W-1:0] result_q;
  logic             err_q;

  // Every element width is built in parallel; esize picks one.
  for (genvar e = 0; e < NUM_ESZ; e++) begin : g_esz
    rsa_lane_array #(.VEC_W(VEC_W), .EW(esz_bits(e)), .SHW(SHW)) u_arr (
      .src_i       (src),
      .acc_i       (acc),
      .is_signed_i (is_signed),
      .shamt_i     (shamt),
      .res_o       (lane_res[e])
    );
  end

  rsa_shamt_check #(.SHW(SHW)) u_chk (
    .esize_i   (esize),
    .shamt_i   (shamt),
    .illegal_o (illegal)
  );

  // Next-state
  always_comb begin
    res_d = illegal ? acc : lane_res[esize];
    if (!wide_sel) begin
      res_d[VEC_W-1:HALF_W] = '0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      err_q    <= 1'b0;
    end else if (in_valid) begin
      result_q <= res_d;
      err_q    <= illegal;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign shamt_err = err_q;

  // R8: output valid tracks input valid with one cycle of latency
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(shamt_err));

  // R6: a zero shift is always illegal and passes the accumulator
  a_r6_zero_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (shamt == '0) |=> shamt_err);
  a_r6_acc_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (shamt == '0) && wide_sel |=> result == $past(acc));

  // R7: narrow vectors leave the upper half of the result at zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide_sel |=> result[VEC_W-1:HALF_W] == '0);
endmodule

// File: tb/rsa_vec_unit_test.sv
module rsa_vec_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         wide_sel;
  logic [1:0]   esize;
  logic         is_signed;
  logic [6:0]   shamt;
  logic [127:0] src;
  logic [127:0] acc;
  logic         out_valid;
  logic [127:0] result;
  logic         shamt_err;

  int nchk  = 0;
  int nfail = 0;
  logic [127:0] last_res;
  logic         last_err;
  bit           done = 1'b0;

  typedef struct {
    logic [127:0] res;
    logic         err;
    string        tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;  // 125 MHz

  rsa_vec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
    .esize(esize), .is_signed(is_signed), .shamt(shamt), .src(src), .acc(acc),
    .out_valid(out_valid), .result(result), .shamt_err(shamt_err)
  );

  function automatic void check(input bit ok, input string tag,
                                input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // Reference, written from the requirements.
  function automatic logic ref_err(input logic [1:0] es, input logic [6:0] n);
    int ew = 8 << es;
    return (n == 0) || (int'(n) > ew);
  endfunction

  function automatic logic [127:0] ref_calc(input logic w, input logic [1:0] es,
      input logic sg, input logic [6:0] n, input logic [127:0] s, input logic [127:0] a);
    int ew = 8 << es;
    int lanes = (w ? 128 : 64) / ew;
    logic [127:0] r = '0;
    if (ref_err(es, n)) begin
      r = a;
      if (!w) r[127:64] = '0;
      return r;
    end
    for (int i = 0; i < lanes; i++) begin
      logic signed [71:0] v;
      logic [63:0] av;
      logic [63:0] t;
      v = '0;
      av = '0;
      for (int b = 0; b < ew; b++) begin
        v[b]  = s[i*ew+b];
        av[b] = a[i*ew+b];
      end
      if (sg && s[i*ew+ew-1]) for (int b = ew; b < 72; b++) v[b] = 1'b1;
      v = v + (72'sd1 <<< (n - 7'd1));
      v = v >>> n;
      t = av + v[63:0];
      for (int b = 0; b < ew; b++) r[i*ew+b] = t[b];
    end
    return r;
  endfunction

  task automatic send(input logic w, input logic [1:0] es, input logic sg,
      input logic [6:0] n, input logic [127:0] s, input logic [127:0] a,
      input logic [127:0] er, input logic ee, input string tag);
    exp_t it;
    in_valid = 1'b1; wide_sel = w; esize = es; is_signed = sg;
    shamt = n; src = s; acc = a;
    it.res = er; it.err = ee; it.tag = tag;
    sbq.push_back(it);
    last_res = er; last_err = ee;
    @(negedge clk);
  endtask

  task automatic send_m(input logic w, input logic [1:0] es, input logic sg,
      input logic [6:0] n, input logic [127:0] s, input logic [127:0] a,
      input string tag);
    send(w, es, sg, n, s, a, ref_calc(w, es, sg, n, s, a), ref_err(es, n), tag);
  endtask

  task automatic idle(input int k);
    in_valid = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected out_valid", {127'd0, out_valid}, 128'd0);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        check(result === it.res, it.tag, result, it.res);
        check(shamt_err === it.err, {it.tag, " err flag"},
              {127'd0, shamt_err}, {127'd0, it.err});
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; wide_sel = 1'b0; esize = 2'd0;
    is_signed = 1'b0; shamt = 7'd1; src = '0; acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(out_valid === 1'b0, "R9 reset out_valid", {127'd0, out_valid}, 128'd0);
    check(result === 128'd0, "R9 reset result", result, 128'd0);
    check(shamt_err === 1'b0, "R9 reset err", {127'd0, shamt_err}, 128'd0);

    // R2: rounding carry kept
    send(1'b0, 2'd0, 1'b0, 7'd1, {16{8'hFF}}, '0, {64'd0, {8{8'h80}}}, 1'b0, "R2 u8 FF>>1");
    send(1'b1, 2'd0, 1'b1, 7'd1, {16{8'h7F}}, '0, {16{8'h40}}, 1'b0, "R2 s8 7F>>1");
    send(1'b1, 2'd0, 1'b1, 7'd3, {16{8'h7F}}, '0, {16{8'h10}}, 1'b0, "R2 s8 7F>>3");
    send(1'b1, 2'd0, 1'b0, 7'd3, {16{8'hFF}}, '0, {16{8'h20}}, 1'b0, "R2 u8 FF>>3");
    send(1'b1, 2'd1, 1'b1, 7'd1, {8{16'h7FFF}}, '0, {8{16'h4000}}, 1'b0, "R2 s16 7FFF>>1");
    send(1'b1, 2'd3, 1'b0, 7'd1, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0,
         {2{64'h8000_0000_0000_0000}}, 1'b0, "R2 u64 ones>>1");
    // R3: arithmetic shift of minimum
    send(1'b0, 2'd0, 1'b1, 7'd1, {16{8'h80}}, '0, {64'd0, {8{8'hC0}}}, 1'b0, "R3 s8 80>>1");
    send(1'b0, 2'd0, 1'b1, 7'd3, {16{8'h80}}, '0, {64'd0, {8{8'hF0}}}, 1'b0, "R3 s8 80>>3");
    send(1'b0, 2'd0, 1'b1, 7'd8, {16{8'h80}}, '0, 128'd0, 1'b0, "R3 s8 80>>8");
    send(1'b1, 2'd3, 1'b1, 7'd1, {2{64'h8000_0000_0000_0000}}, '0,
         {2{64'hC000_0000_0000_0000}}, 1'b0, "R3 s64 min>>1");
    // R4: full-width shift
    send(1'b1, 2'd2, 1'b0, 7'd32, {4{32'hFFFF_FFFF}}, '0, {4{32'h1}}, 1'b0, "R4 u32 ones>>32");
    send(1'b1, 2'd3, 1'b1, 7'd64, {2{64'h7FFF_FFFF_FFFF_FFFF}}, '0, 128'd0, 1'b0, "R4 s64 max>>64");
    // R5 / R1: per-lane wrap, no carry into the neighbour
    send(1'b0, 2'd1, 1'b0, 7'd3, {8{16'h0008}}, {64'd0, 64'h0001_FFFF_0001_FFFF},
         {64'd0, 64'h0002_0000_0002_0000}, 1'b0, "R5 R1 u16 wrap");
    send(1'b1, 2'd0, 1'b1, 7'd1, {16{8'h02}}, {8{16'h7FFF}}, {8{16'h8000}}, 1'b0, "R5 R1 s8 wrap");
    // R6: illegal shifts
    send(1'b1, 2'd2, 1'b0, 7'd0, {4{32'h1234_5678}}, {4{32'hCAFE_F00D}},
         {4{32'hCAFE_F00D}}, 1'b1, "R6 shift 0");
    send(1'b0, 2'd0, 1'b0, 7'd9, {16{8'hFF}}, {16{8'hAA}}, {64'd0, {8{8'hAA}}}, 1'b1, "R6 u8 shift 9");
    send(1'b1, 2'd3, 1'b0, 7'd65, {2{64'd5}}, {2{64'd9}}, {2{64'd9}}, 1'b1, "R6 u64 shift 65");
    // R7: upper halves ignored in narrow mode
    send(1'b0, 2'd3, 1'b0, 7'd64, {64'h1234_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
         {64'hDEAD_BEEF_DEAD_BEEF, 64'd0}, {64'd0, 64'd1}, 1'b0, "R7 narrow u64");
    // Randomized, back-to-back (R1 R8)
    for (int k = 0; k < 48; k++) begin
      logic [1:0] es = 2'($urandom % 4);
      int ew = 8 << es;
      logic [6:0] n = (k % 8 == 7) ? 7'(ew + 1) : 7'(1 + ($urandom % ew));
      send_m(1'($urandom), es, 1'($urandom), n,
             {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom}, "R1 random");
    end
    idle(3);
    // R8: no new output, result holds
    check(out_valid === 1'b0, "R8 idle out_valid", {127'd0, out_valid}, 128'd0);
    check(result === last_res, "R8 hold result", result, last_res);
    check(shamt_err === last_err, "R8 hold err", {127'd0, shamt_err}, {127'd0, last_err});
    check(sbq.size() == 0, "R8 all items returned", 128'(sbq.size()), 128'd0);
    // R9: asynchronous clear mid-run
    send(1'b1, 2'd0, 1'b0, 7'd1, {16{8'hFF}}, '0, {16{8'h80}}, 1'b0, "R2 before reset");
    idle(1);
    #2 rst_n = 1'b0;
    #1;
    check(result === 128'd0, "R9 async clear result", result, 128'd0);
    check(out_valid === 1'b0, "R9 async clear valid", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    done = 1'b1;
    finish_run();
  end
endmodule